// File: doc/BRIEF.md
# Indexed Color Palette Register Port

This block is the host side of a color lookup converter. A host reaches three storage spaces through one shared internal index and a 2-bit register select. The spaces are 256 main color entries, 4 overlay color entries and 4 control bytes. The index counts entry × 4 + component. Bytes are written or read one color component at a time, in the order red, green, blue. After each byte the index steps on by itself.

The first two written components of an entry wait in a shadow pair. The entry is updated only when the blue byte arrives. At that point the whole 24-bit triple is written at once, and the index skips the unused fourth slot to reach the next entry. Each commit that changes the stored color raises a one-cycle change pulse.

The pixel path looks up main and overlay entries as packed 24-bit words on separate combinational ports. The block also decodes the overlay plane enables and the blink frame counts from the mode control byte.

Top module: `pal_dac_port`

## Requirements
- R1: Register 0 selects the index. Writing value v sets the index to entry v, component 0. Reading register 0 returns the current entry number.
- R2: Register 1 writes a component into the main space: component 0 = red, 1 = green, 2 = blue. The entry changes only when the blue byte is written, and the index then moves to component 0 of the next entry.
- R3: In the main space, stepping past entry 255 wraps the index to entry 0.
- R4: Reading register 1 returns the addressed component of the stored main entry and advances the index by the same rule as a write.
- R5: If the index is reloaded before the blue byte arrives, the partly written entry keeps its old color.
- R6: Register 3 reaches overlay entry n (0 to 3) while the index is below entry 4. Writes commit on the blue byte, and the index wraps from overlay entry 3 to entry 0.
- R7: When the index is at entry 4 or above, register 3 has no effect. Writes store nothing, the index does not move, and reads return 0.
- R8: Register 2 reads and writes control byte (entry − 4) while the index is at entries 4 to 7. At other entries its writes are ignored and its reads return 0. A register 2 access never moves the index.
- R9: Bits 1:0 of control byte 2 (entry 6) drive the overlay plane enables 1:0.
- R10: Bits 5:4 of control byte 2 select the blink on/off frame counts: 0 gives 16/48, 1 gives 16/16, 2 gives 32/32, 3 gives 64/64.
- R11: The change output pulses for exactly one cycle, in the cycle after a commit whose RGB differs from the stored entry. It stays low after any other access.
- R12: The lookup ports return the stored entry combinationally, packed as red in 23:16, green in 15:8 and blue in 7:0.
- R13: After reset the index is 0, all entries and control bytes are 0, the plane enables are 0 and the blink counts are 16/48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Host access strobe, one cycle per byte |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_reg_i | input | 2 | Register select: 0 index, 1 main, 2 control, 3 overlay |
| acc_wdata_i | input | 8 | Write byte |
| acc_rdata_o | output | 8 | Read byte for the current access (combinational) |
| pix_idx_i | input | 8 | Main lookup entry |
| pix_rgb_o | output | 24 | Packed main entry |
| ovl_idx_i | input | 2 | Overlay lookup entry |
| ovl_rgb_o | output | 24 | Packed overlay entry |
| ovl_en_o | output | 2 | Overlay plane enables |
| blink_on_o | output | 7 | Blink on frame count |
| blink_off_o | output | 7 | Blink off frame count |
| pal_changed_o | output | 1 | One-cycle pulse after a commit that changed an entry |

## Verification
Main-space writes are tried with three distinct bytes per entry. This shows whether the component order is right, and the index read-back afterwards shows whether the fourth slot is skipped. Writes at entry 255 and at overlay entry 3 separate the wide wrap from the narrow one. A rewrite of identical colors shows whether the change pulse compares against stored data rather than firing on every commit. Control accesses at entries 3, 4, 6 and 8 check the window edges, and all four blink codes are applied to check the decode table.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    REG_INDEX = 2'd0,
    REG_MAIN  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_OVL   = 2'd3
  } dac_reg_e;

  typedef struct packed {
    logic [6:0] on_cnt;
    logic [6:0] off_cnt;
  } blink_t;

  function automatic blink_t blink_decode(input logic [1:0] code);
    blink_t b;
    unique case (code)
      2'd0:    b = '{on_cnt: 7'd16, off_cnt: 7'd48};
      2'd1:    b = '{on_cnt: 7'd16, off_cnt: 7'd16};
      2'd2:    b = '{on_cnt: 7'd32, off_cnt: 7'd32};
      default: b = '{on_cnt: 7'd64, off_cnt: 7'd64};
    endcase
    return b;
  endfunction

  function automatic logic [7:0] rgb_byte(input logic [23:0] rgb, input logic [1:0] comp);
    unique case (comp)
      2'd0:    return rgb[23:16];
      2'd1:    return rgb[15:8];
      default: return rgb[7:0];
    endcase
  endfunction
endpackage

// File: rtl/pal_dac_index.sv
module pal_dac_index #(
  parameter int IDXW    = 10,
  parameter int OVL_LIM = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [IDXW-3:0] load_entry_i,
  input  logic            step_i,
  input  logic            ovl_wrap_i,
  output logic [IDXW-1:0] idx_o
);
  logic [IDXW-1:0] idx_q, idx_inc;

  always_comb begin
    idx_inc = idx_q + IDXW'(1);
    // slot 3 of every entry is unused
    if (idx_inc[1:0] == 2'b11) idx_inc = idx_inc + IDXW'(1);
    if (ovl_wrap_i && idx_inc >= IDXW'(OVL_LIM)) idx_inc = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (load_i) idx_q <= {load_entry_i, 2'b00};
    else if (step_i) idx_q <= idx_inc;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [23:0]   wrgb_i,
  output logic          diff_o,
  input  logic [AW-1:0] raddr_i,
  output logic [23:0]   rrgb_o,
  input  logic [AW-1:0] paddr_i,
  output logic [23:0]   prgb_o
);
  logic [23:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wrgb_i;
    end
  end

  assign diff_o = (mem_q[waddr_i] != wrgb_i);
  assign rrgb_o = mem_q[raddr_i];
  assign prgb_o = mem_q[paddr_i];
endmodule

// File: rtl/pal_dac_ctrl.sv
module pal_dac_ctrl
  import pal_dac_pkg::*;
#(
  parameter int NUM_CTRL = 4,
  parameter int MODE_SEL = 2,
  parameter int SW       = $clog2(NUM_CTRL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [1:0]    ovl_en_o,
  output logic [6:0]    blink_on_o,
  output logic [6:0]    blink_off_o
);
  logic [7:0] ctrl_q [NUM_CTRL];
  blink_t     rate;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ctrl_q[g] <= '0;
      else if (we_i && sel_i == SW'(g))     ctrl_q[g] <= wdata_i;
    end
  end

  assign rdata_o     = ctrl_q[sel_i];
  assign ovl_en_o    = ctrl_q[MODE_SEL][1:0];
  assign rate        = blink_decode(ctrl_q[MODE_SEL][5:4]);
  assign blink_on_o  = rate.on_cnt;
  assign blink_off_o = rate.off_cnt;
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int NUM_MAIN  = 256,
  parameter int NUM_OVL   = 4,
  parameter int NUM_CTRL  = 4,
  parameter int CTRL_BASE = 4,
  parameter int MODE_REG  = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_en_i,
  input  logic                        acc_we_i,
  input  logic [1:0]                  acc_reg_i,
  input  logic [7:0]                  acc_wdata_i,
  output logic [7:0]                  acc_rdata_o,
  input  logic [$clog2(NUM_MAIN)-1:0] pix_idx_i,
  output logic [23:0]                 pix_rgb_o,
  input  logic [$clog2(NUM_OVL)-1:0]  ovl_idx_i,
  output logic [23:0]                 ovl_rgb_o,
  output logic [1:0]                  ovl_en_o,
  output logic [6:0]                  blink_on_o,
  output logic [6:0]                  blink_off_o,
  output logic                        pal_changed_o
);
  localparam int MAINAW  = $clog2(NUM_MAIN);
  localparam int OVLAW   = $clog2(NUM_OVL);
  localparam int CSELW   = $clog2(NUM_CTRL);
  localparam int IDXW    = MAINAW + 2;
  localparam int OVL_LIM = NUM_OVL * 4;
  localparam int CTRL_LO = CTRL_BASE * 4;
  localparam int CTRL_HI = (CTRL_BASE + NUM_CTRL) * 4;

  logic [IDXW-1:0]   idx_q;
  logic [MAINAW-1:0] entry;
  logic [1:0]        comp;
  logic              ovl_ok, ctrl_ok;
  logic              main_hit, ovl_hit, idx_load, last_comp;
  logic              main_wr, ovl_wr, main_diff, ovl_diff;
  logic [7:0]        shadow_q [2];
  logic [23:0]       commit_rgb, main_rd_rgb, ovl_rd_rgb;
  logic [MAINAW-1:0] ctrl_off;
  logic [7:0]        ctrl_rdata;
  logic              chg_q;

  assign entry     = idx_q[IDXW-1:2];
  assign comp      = idx_q[1:0];
  assign ovl_ok    = idx_q < IDXW'(OVL_LIM);
  assign ctrl_ok   = idx_q >= IDXW'(CTRL_LO) && idx_q < IDXW'(CTRL_HI);
  assign ctrl_off  = entry - MAINAW'(CTRL_BASE);
  assign idx_load  = acc_en_i && acc_we_i && acc_reg_i == REG_INDEX;
  assign main_hit  = acc_en_i && acc_reg_i == REG_MAIN;
  assign ovl_hit   = acc_en_i && acc_reg_i == REG_OVL && ovl_ok;
  assign last_comp = comp == 2'd2;
  assign main_wr   = main_hit && acc_we_i && last_comp;
  assign ovl_wr    = ovl_hit && acc_we_i && last_comp;
  assign commit_rgb = {shadow_q[0], shadow_q[1], acc_wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q[0] <= '0;
      shadow_q[1] <= '0;
    end else if ((main_hit || ovl_hit) && acc_we_i && !comp[1]) begin
      shadow_q[comp[0]] <= acc_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= (main_wr && main_diff) || (ovl_wr && ovl_diff);
  end
  assign pal_changed_o = chg_q;

  pal_dac_index #(.IDXW(IDXW), .OVL_LIM(OVL_LIM)) u_index (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (idx_load),
    .load_entry_i (MAINAW'(acc_wdata_i)),
    .step_i       (main_hit || ovl_hit),
    .ovl_wrap_i   (ovl_hit),
    .idx_o        (idx_q)
  );

  pal_dac_store #(.DEPTH(NUM_MAIN)) u_main (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (main_wr),
    .waddr_i (entry),
    .wrgb_i  (commit_rgb),
    .diff_o  (main_diff),
    .raddr_i (entry),
    .rrgb_o  (main_rd_rgb),
    .paddr_i (pix_idx_i),
    .prgb_o  (pix_rgb_o)
  );

  pal_dac_store #(.DEPTH(NUM_OVL)) u_ovl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ovl_wr),
    .waddr_i (entry[OVLAW-1:0]),
    .wrgb_i  (commit_rgb),
    .diff_o  (ovl_diff),
    .raddr_i (entry[OVLAW-1:0]),
    .rrgb_o  (ovl_rd_rgb),
    .paddr_i (ovl_idx_i),
    .prgb_o  (ovl_rgb_o)
  );

  pal_dac_ctrl #(.NUM_CTRL(NUM_CTRL), .MODE_SEL(MODE_REG - CTRL_BASE)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (acc_en_i && acc_we_i && acc_reg_i == REG_CTRL && ctrl_ok),
    .sel_i       (ctrl_off[CSELW-1:0]),
    .wdata_i     (acc_wdata_i),
    .rdata_o     (ctrl_rdata),
    .ovl_en_o    (ovl_en_o),
    .blink_on_o  (blink_on_o),
    .blink_off_o (blink_off_o)
  );

  always_comb begin
    acc_rdata_o = '0;
    unique case (acc_reg_i)
      REG_INDEX: acc_rdata_o = 8'(entry);
      REG_MAIN:  acc_rdata_o = rgb_byte(main_rd_rgb, comp);
      REG_CTRL:  if (ctrl_ok) acc_rdata_o = ctrl_rdata;
      default:   if (ovl_ok) acc_rdata_o = rgb_byte(ovl_rd_rgb, comp);
    endcase
  end
endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk #(
  parameter int IDXW    = 10,
  parameter int OVL_LIM = 16,
  parameter int CTRL_LO = 16,
  parameter int CTRL_HI = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            acc_en_i,
  input logic            acc_we_i,
  input logic [1:0]      acc_reg_i,
  input logic [7:0]      acc_wdata_i,
  input logic [IDXW-1:0] idx_i,
  input logic            pal_changed_i,
  input logic [1:0]      ovl_en_i,
  input logic [6:0]      blink_on_i,
  input logic [6:0]      blink_off_i
);
  // R1
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && acc_we_i && acc_reg_i == 2'd0 |=> idx_i == IDXW'({$past(acc_wdata_i), 2'b00}));

  // R2
  idx_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_i[1:0] != 2'b11);

  // R6
  ovl_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && acc_reg_i == 2'd3 && idx_i < IDXW'(OVL_LIM) |=> idx_i < IDXW'(OVL_LIM));

  // R8
  ctrl_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && acc_reg_i == 2'd2 |=> $stable(idx_i));

  // R8
  ctrl_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && acc_we_i && acc_reg_i == 2'd2 && (idx_i < IDXW'(CTRL_LO) || idx_i >= IDXW'(CTRL_HI))
    |=> $stable(ovl_en_i) && $stable(blink_on_i) && $stable(blink_off_i));

  // R11
  chg_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_changed_i |-> $past(acc_en_i && acc_we_i && acc_reg_i[0]));
endmodule

bind pal_dac_port pal_dac_port_chk #(
  .IDXW(IDXW), .OVL_LIM(OVL_LIM), .CTRL_LO(CTRL_LO), .CTRL_HI(CTRL_HI)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_en_i      (acc_en_i),
  .acc_we_i      (acc_we_i),
  .acc_reg_i     (acc_reg_i),
  .acc_wdata_i   (acc_wdata_i),
  .idx_i         (idx_q),
  .pal_changed_i (pal_changed_o),
  .ovl_en_i      (ovl_en_o),
  .blink_on_i    (blink_on_o),
  .blink_off_i   (blink_off_o)
);

// File: tb/pal_dac_port_tb.sv
module pal_dac_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0, we = 0;
  logic [1:0]  rsel = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [7:0]  pix_idx = 0;
  logic [1:0]  ovl_idx = 0;
  logic [23:0] pix_rgb, ovl_rgb;
  logic [1:0]  ovl_en;
  logic [6:0]  b_on, b_off;
  logic        chg;
  int n_chk = 0, n_fail = 0;
  logic last_chg;
  logic [7:0] rd;
  bit done = 0;

  always #2 clk = ~clk;

  pal_dac_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(en), .acc_we_i(we), .acc_reg_i(rsel),
    .acc_wdata_i(wdata), .acc_rdata_o(rdata), .pix_idx_i(pix_idx), .pix_rgb_o(pix_rgb),
    .ovl_idx_i(ovl_idx), .ovl_rgb_o(ovl_rgb), .ovl_en_o(ovl_en), .blink_on_o(b_on),
    .blink_off_o(b_off), .pal_changed_o(chg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [7:0] d);
    @(negedge clk); en = 1; we = 1; rsel = r; wdata = d;
    @(negedge clk); en = 0; we = 0;
    last_chg = chg;
  endtask

  task automatic rdreg(input logic [1:0] r, output logic [7:0] d);
    @(negedge clk); en = 1; we = 0; rsel = r;
    #1 d = rdata;
    @(negedge clk); en = 0;
  endtask

  task automatic t_reset();
    rdreg(2'd0, rd);
    check("R13 index", rd, 0);
    check("R13 ovl_en", ovl_en, 0);
    check("R13 blink", {b_on, b_off}, {7'd16, 7'd48});
    pix_idx = 8'd9; #1 check("R13 entry", pix_rgb, 0);
  endtask

  task automatic t_main_write();
    wr(2'd0, 8'd5); check("R1 reload", chg, 0);
    wr(2'd1, 8'h11); check("R2 no pulse R", last_chg, 0);
    wr(2'd1, 8'h22); check("R2 no pulse G", last_chg, 0);
    pix_idx = 8'd5; #1 check("R2 not yet committed", pix_rgb, 0);
    wr(2'd1, 8'h33); check("R11 pulse on commit", last_chg, 1);
    @(negedge clk); check("R11 pulse one cycle", chg, 0);
    #1 check("R12 packed entry", pix_rgb, 24'h112233);
    rdreg(2'd0, rd); check("R2 next entry", rd, 6);
  endtask

  task automatic t_main_read();
    wr(2'd0, 8'd5);
    rdreg(2'd1, rd); check("R4 read red", rd, 8'h11);
    rdreg(2'd1, rd); check("R4 read green", rd, 8'h22);
    rdreg(2'd1, rd); check("R4 read blue", rd, 8'h33);
    rdreg(2'd0, rd); check("R4 read advance", rd, 6);
    wr(2'd0, 8'd5);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    check("R11 same color no pulse", last_chg, 0);
  endtask

  task automatic t_wrap_partial();
    wr(2'd0, 8'd255);
    wr(2'd1, 8'hA1); wr(2'd1, 8'hB2); wr(2'd1, 8'hC3);
    pix_idx = 8'd255; #1 check("R3 last entry", pix_rgb, 24'hA1B2C3);
    rdreg(2'd0, rd); check("R3 wrap to 0", rd, 0);
    wr(2'd0, 8'd7); wr(2'd1, 8'h44); wr(2'd1, 8'h55);
    wr(2'd0, 8'd7);
    pix_idx = 8'd7; #1 check("R5 partial dropped", pix_rgb, 0);
  endtask

  task automatic t_overlay();
    wr(2'd0, 8'd2);
    wr(2'd3, 8'h0A); wr(2'd3, 8'h0B); wr(2'd3, 8'h0C);
    check("R11 overlay pulse", last_chg, 1);
    ovl_idx = 2'd2; #1 check("R6 overlay entry", ovl_rgb, 24'h0A0B0C);
    pix_idx = 8'd2; #1 check("R6 main untouched", pix_rgb, 0);
    wr(2'd0, 8'd3);
    wr(2'd3, 8'h01); wr(2'd3, 8'h02); wr(2'd3, 8'h03);
    rdreg(2'd0, rd); check("R6 overlay wrap", rd, 0);
    wr(2'd0, 8'd2);
    rdreg(2'd3, rd); check("R6 overlay read", rd, 8'h0A);
    wr(2'd0, 8'd4);
    wr(2'd3, 8'hEE); wr(2'd3, 8'hEE); wr(2'd3, 8'hEE);
    check("R7 no pulse", last_chg, 0);
    rdreg(2'd0, rd); check("R7 index held", rd, 4);
    rdreg(2'd3, rd); check("R7 read zero", rd, 0);
    ovl_idx = 2'd0; #1 check("R7 overlay 0 untouched", ovl_rgb, 0);
  endtask

  task automatic t_control();
    wr(2'd0, 8'd6); wr(2'd2, 8'h23);
    check("R9 enables", ovl_en, 2'b11);
    check("R10 code2", {b_on, b_off}, {7'd32, 7'd32});
    rdreg(2'd2, rd); check("R8 readback", rd, 8'h23);
    rdreg(2'd0, rd); check("R8 index held", rd, 6);
    wr(2'd2, 8'h11); check("R10 code1", {b_on, b_off}, {7'd16, 7'd16});
    check("R9 plane0 only", ovl_en, 2'b01);
    wr(2'd2, 8'h32); check("R10 code3", {b_on, b_off}, {7'd64, 7'd64});
    check("R9 plane1 only", ovl_en, 2'b10);
    wr(2'd2, 8'h00); check("R10 code0", {b_on, b_off}, {7'd16, 7'd48});
    wr(2'd0, 8'd4); wr(2'd2, 8'hAB);
    rdreg(2'd2, rd); check("R8 ctrl byte 0", rd, 8'hAB);
    check("R9 mode unaffected", ovl_en, 0);
    wr(2'd0, 8'd8); wr(2'd2, 8'h33);
    check("R8 above window ignored", ovl_en, 0);
    rdreg(2'd2, rd); check("R8 above window reads 0", rd, 0);
    wr(2'd0, 8'd3); wr(2'd2, 8'h33);
    check("R8 below window ignored", {ovl_en, b_on}, {2'b00, 7'd16});
    rdreg(2'd2, rd); check("R8 below window reads 0", rd, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_main_write();
    t_main_read();
    t_wrap_partial();
    t_overlay();
    t_control();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule